// File: doc/BRIEF.md
# Cache Hit/Miss Statistics Counter

This block keeps hit and miss counts for a cache. Each count sits in two dimensions: the command type of the access and a requester bucket. The cache pulses `hit_i` or `miss_i` once for each access it resolves. Along with the strobe it supplies the command index, a writeback flag, a device flag and the requester's context ID. The block turns those inputs into a bucket and increments one saturating counter in the hit array or the miss array.

There is one bucket for each CPU, plus one extra bucket for device traffic. Writebacks carry no usable context, so they always land in bucket 0. A writeback that does carry a real context ID raises a sticky error flag and is still counted. A loadable miss budget counts down on each miss. When the budget runs out, it raises a one-cycle stop pulse that a harness can use to halt a run. A registered read port returns any single counter.

Top module: `hm_stats_counter`

## Requirements
- R1: An access with `wb_i` high is counted in bucket 0, for both hits and misses, whatever `dev_i` and `ctx_i` are.
- R2: An access with `dev_i` high and `wb_i` low is counted in bucket `NUM_CPUS`.
- R3: Any other access is counted in bucket `ctx_i mod NUM_CPUS`.
- R4: Hits and misses are kept in separate arrays indexed by (`cmd_i`, bucket). A cycle with both strobes high increments the matching entry of each array, and no other entry changes.
- R5: Each counter saturates at 2^CNT_W-1 and holds there under further increments.
- R6: Loading a miss budget N>0 through `lim_load_i`/`lim_val_i` makes `stop_o` high for exactly the one cycle that follows the clock edge of the Nth later miss. Hits do not consume the budget. Further misses give no further pulse until the next load.
- R7: A loaded budget of 0 disables the stop pulse: `stop_o` stays low however many misses arrive.
- R8: A writeback strobe whose `ctx_i` is not all-ones sets `err_o` from the next cycle on. `err_o` stays set until `clr_i`, and the access is still counted in bucket 0.
- R9: A read request (`rd_en_i`, with `rd_miss_i` = 1 for the miss array and 0 for the hit array, plus `rd_cmd_i` and `rd_bkt_i`) returns the counter on `rd_data_o` with `rd_valid_o` high in the next cycle. `rd_valid_o` is low in any cycle that follows no request.
- R10: `clr_i` zeroes every counter and `err_o` in the next cycle and leaves the miss budget untouched. After reset all counters, `err_o`, `stop_o` and `rd_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Synchronous clear of counters and error flag |
| hit_i | input | 1 | Hit strobe |
| miss_i | input | 1 | Miss strobe |
| cmd_i | input | CMD_W | Command-type index of the access |
| wb_i | input | 1 | Access is a writeback |
| dev_i | input | 1 | Access comes from a device, not a CPU |
| ctx_i | input | CTX_W | Requester context ID (all-ones means none) |
| lim_load_i | input | 1 | Load a new miss budget |
| lim_val_i | input | LIM_W | Miss budget value (0 disables stop) |
| stop_o | output | 1 | One-cycle pulse when the budget is exhausted |
| err_o | output | 1 | Sticky: writeback seen with a context ID |
| rd_en_i | input | 1 | Read request |
| rd_miss_i | input | 1 | Read selects miss array (1) or hit array (0) |
| rd_cmd_i | input | CMD_W | Read command index |
| rd_bkt_i | input | BKT_W | Read bucket index |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | CNT_W | Read data |

## Verification
A strobe at a clock edge updates its counter, `err_o` and `stop_o` at that same edge, so these are due one cycle after the inputs are presented. Read data and `rd_valid_o` come one cycle after the read request. The bench drives every input on the falling edge and holds it for one cycle. It samples the flags on the next falling edge, and it issues reads only after the access strobe has been removed. Each result is therefore observed exactly one edge after its cause, and no read overlaps an update.

// File: rtl/hm_stats_pkg.sv
package hm_stats_pkg;

  // Bucket choice: writeback first, then device, else CPU context folded.
  function automatic int unsigned pick_bucket(input logic wb, input logic dev,
                                              input int unsigned ctx,
                                              input int unsigned ncpu);
    if (wb)       return 0;
    else if (dev) return ncpu;
    else          return ctx % ncpu;
  endfunction

endpackage

// File: rtl/hm_bucket_sel.sv
module hm_bucket_sel #(
  parameter int NUM_CPUS = 3,
  parameter int CTX_W    = 4,
  parameter int BKT_W    = 2
) (
  input  logic             wb_i,
  input  logic             dev_i,
  input  logic [CTX_W-1:0] ctx_i,
  output logic [BKT_W-1:0] bkt_o
);
  import hm_stats_pkg::*;

  assign bkt_o = BKT_W'(pick_bucket(wb_i, dev_i, 32'(ctx_i), NUM_CPUS));
endmodule

// File: rtl/hm_cnt_array.sv
module hm_cnt_array #(
  parameter int NUM_CMDS = 4,
  parameter int NBKT     = 4,
  parameter int CNT_W    = 32,
  parameter int CMD_W    = 2,
  parameter int BKT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [BKT_W-1:0] bkt_i,
  input  logic [CMD_W-1:0] rd_cmd_i,
  input  logic [BKT_W-1:0] rd_bkt_i,
  output logic [CNT_W-1:0] rd_val_o
);
  localparam int NENT  = NUM_CMDS * NBKT;
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q [NENT];
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             rd_in_range;

  assign wr_idx      = IDX_W'(int'(cmd_i) * NBKT + int'(bkt_i));
  assign rd_idx      = IDX_W'(int'(rd_cmd_i) * NBKT + int'(rd_bkt_i));
  assign rd_in_range = (int'(rd_cmd_i) < NUM_CMDS) && (int'(rd_bkt_i) < NBKT);
  assign rd_val_o    = rd_in_range ? cnt_q[rd_idx] : '0;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NENT; i++) begin
      if (!rst_n || clr_i)
        cnt_q[i] <= '0;
      else if (inc_i && wr_idx == IDX_W'(i))
        cnt_q[i] <= sat_inc(cnt_q[i]);
    end
  end
endmodule

// File: rtl/hm_miss_limit.sv
module hm_miss_limit #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LIM_W-1:0] load_val_i,
  input  logic             miss_i,
  output logic             stop_o,
  output logic [LIM_W-1:0] rem_o
);
  logic [LIM_W-1:0] rem_q;
  logic             stop_q;

  function automatic logic last_step(input logic [LIM_W-1:0] r);
    return r == LIM_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      stop_q <= 1'b0;
      if (load_i)
        rem_q <= load_val_i;
      else if (miss_i && rem_q != '0) begin
        rem_q  <= rem_q - 1'b1;
        stop_q <= last_step(rem_q);
      end
    end
  end

  assign stop_o = stop_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/hm_stats_counter.sv
module hm_stats_counter #(
  parameter int NUM_CPUS = 3,
  parameter int NUM_CMDS = 4,
  parameter int CNT_W    = 32,
  parameter int CTX_W    = 4,
  parameter int LIM_W    = 16,
  localparam int NBKT    = NUM_CPUS + 1,
  localparam int BKT_W   = (NBKT > 1) ? $clog2(NBKT) : 1,
  localparam int CMD_W   = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic             miss_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             wb_i,
  input  logic             dev_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic             lim_load_i,
  input  logic [LIM_W-1:0] lim_val_i,
  output logic             stop_o,
  output logic             err_o,
  input  logic             rd_en_i,
  input  logic             rd_miss_i,
  input  logic [CMD_W-1:0] rd_cmd_i,
  input  logic [BKT_W-1:0] rd_bkt_i,
  output logic             rd_valid_o,
  output logic [CNT_W-1:0] rd_data_o
);
  // Named internal events, visible to the bound checker.
  logic [BKT_W-1:0] acc_bkt;
  logic [LIM_W-1:0] lim_rem;
  logic             wb_ctx_bad;
  logic [CNT_W-1:0] arr_val [2];
  logic             arr_inc [2];

  hm_bucket_sel #(.NUM_CPUS(NUM_CPUS), .CTX_W(CTX_W), .BKT_W(BKT_W)) sel_i (
    .wb_i(wb_i), .dev_i(dev_i), .ctx_i(ctx_i), .bkt_o(acc_bkt)
  );

  assign arr_inc[0] = hit_i;
  assign arr_inc[1] = miss_i;

  // Index 0 holds hits, index 1 holds misses.
  for (genvar a = 0; a < 2; a++) begin : g_arr
    hm_cnt_array #(
      .NUM_CMDS(NUM_CMDS), .NBKT(NBKT), .CNT_W(CNT_W),
      .CMD_W(CMD_W), .BKT_W(BKT_W)
    ) arr_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .inc_i(arr_inc[a]),
      .cmd_i(cmd_i), .bkt_i(acc_bkt),
      .rd_cmd_i(rd_cmd_i), .rd_bkt_i(rd_bkt_i), .rd_val_o(arr_val[a])
    );
  end

  hm_miss_limit #(.LIM_W(LIM_W)) lim_i (
    .clk(clk), .rst_n(rst_n), .load_i(lim_load_i), .load_val_i(lim_val_i),
    .miss_i(miss_i), .stop_o(stop_o), .rem_o(lim_rem)
  );

  assign wb_ctx_bad = (hit_i || miss_i) && wb_i && (ctx_i != {CTX_W{1'b1}});

  logic err_q, rd_valid_q;
  logic [CNT_W-1:0] rd_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      if (clr_i)           err_q <= 1'b0;
      else if (wb_ctx_bad) err_q <= 1'b1;
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_data_q <= arr_val[rd_miss_i];
    end
  end

  assign err_o      = err_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/hm_stats_chk.sv
module hm_stats_chk #(
  parameter int NUM_CPUS = 3,
  parameter int BKT_W    = 2,
  parameter int LIM_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             hit_i,
  input logic             miss_i,
  input logic             wb_i,
  input logic             dev_i,
  input logic [BKT_W-1:0] acc_bkt,
  input logic [LIM_W-1:0] lim_rem,
  input logic             lim_load_i,
  input logic             stop_o,
  input logic             err_o,
  input logic             rd_en_i,
  input logic             rd_valid_o
);
  AST_WB_BUCKET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_i || miss_i) && wb_i) |-> (acc_bkt == '0)); // R1
  AST_DEV_BUCKET: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_i || miss_i) && !wb_i && dev_i) |-> (acc_bkt == BKT_W'(NUM_CPUS))); // R2
  AST_CPU_BUCKET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_i || miss_i) && !wb_i && !dev_i) |-> (acc_bkt < BKT_W'(NUM_CPUS))); // R3
  AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o); // R6
  AST_STOP_FROM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> $past(miss_i)); // R6
  AST_ZERO_BUDGET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_rem == '0 && !lim_load_i) |=> !stop_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> err_o); // R8
  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o); // R9
  AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o); // R9
  AST_CLR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !err_o); // R10
endmodule

bind hm_stats_counter hm_stats_chk #(
  .NUM_CPUS(NUM_CPUS), .BKT_W(BKT_W), .LIM_W(LIM_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .hit_i(hit_i), .miss_i(miss_i),
  .wb_i(wb_i), .dev_i(dev_i), .acc_bkt(acc_bkt), .lim_rem(lim_rem),
  .lim_load_i(lim_load_i), .stop_o(stop_o), .err_o(err_o),
  .rd_en_i(rd_en_i), .rd_valid_o(rd_valid_o)
);

// File: tb/hm_stats_counter_tb_top.sv
module hm_stats_counter_tb_top;
  localparam int NCPU = 3;
  localparam int CW   = 4;   // small counters so saturation is reachable
  localparam int XW   = 4;
  localparam int LW   = 8;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 0, hit = 0, miss = 0, wb = 0, dev = 0, lload = 0;
  logic rd_en = 0, rd_miss = 0;
  logic [1:0] cmd = 0, rd_cmd = 0, rd_bkt = 0;
  logic [XW-1:0] ctx = 0;
  logic [LW-1:0] lval = 0;
  logic stop, err, rd_valid;
  logic [CW-1:0] rd_data;
  int n_checks = 0, n_fail = 0;
  logic last_stop, last_err;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hm_stats_counter #(.NUM_CPUS(NCPU), .NUM_CMDS(4), .CNT_W(CW), .CTX_W(XW), .LIM_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .hit_i(hit), .miss_i(miss),
    .cmd_i(cmd), .wb_i(wb), .dev_i(dev), .ctx_i(ctx),
    .lim_load_i(lload), .lim_val_i(lval), .stop_o(stop), .err_o(err),
    .rd_en_i(rd_en), .rd_miss_i(rd_miss), .rd_cmd_i(rd_cmd), .rd_bkt_i(rd_bkt),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  // Bench's own bucket rule, written as repeated subtraction.
  function automatic int exp_bucket(bit w, bit d, int c);
    int r = c;
    if (w) return 0;
    if (d) return NCPU;
    while (r >= NCPU) r -= NCPU;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(bit h, bit m, int c, bit w, bit d, int x);
    @(negedge clk);
    hit = h; miss = m; cmd = 2'(c); wb = w; dev = d; ctx = XW'(x);
    @(negedge clk);
    hit = 0; miss = 0; wb = 0; dev = 0;
    last_stop = stop; last_err = err;
  endtask

  task automatic read(bit m, int c, int b, output int val);
    @(negedge clk);
    rd_en = 1; rd_miss = m; rd_cmd = 2'(c); rd_bkt = 2'(b);
    @(negedge clk);
    rd_en = 0;
    val = int'(rd_data);
  endtask

  task automatic load_limit(int v);
    @(negedge clk); lload = 1; lval = LW'(v);
    @(negedge clk); lload = 0;
  endtask

  task automatic t_reset();
    int v;
    check("R10 err after reset", int'(err), 0);
    check("R10 stop after reset", int'(stop), 0);
    check("R10 rd_valid after reset", int'(rd_valid), 0);
    read(0, 2, 1, v); check("R10 counter zero after reset", v, 0);
  endtask

  task automatic t_cpu_buckets();
    int v;
    access(1, 0, 1, 0, 0, 7);
    access(0, 1, 2, 0, 0, 5);
    access(1, 0, 0, 0, 0, 0);
    read(0, 1, exp_bucket(0, 0, 7), v); check("R3 hit ctx7", v, 1);
    read(1, 2, exp_bucket(0, 0, 5), v); check("R3 miss ctx5", v, 1);
    read(0, 0, 0, v);                   check("R3 hit ctx0", v, 1);
    read(0, 2, 2, v);                   check("R4 hit array untouched by miss", v, 0);
    read(0, 1, 2, v);                   check("R4 other bucket untouched", v, 0);
  endtask

  task automatic t_writeback();
    int v;
    access(1, 0, 3, 1, 0, 15);
    check("R8 no error for ctx none", int'(last_err), 0);
    access(0, 1, 3, 1, 1, 2);
    check("R8 error set by ctx on writeback", int'(last_err), 1);
    read(0, 3, 0, v); check("R1 wb hit bucket0", v, 1);
    read(1, 3, 0, v); check("R1 R8 wb miss with dev counted bucket0", v, 1);
    read(1, 3, NCPU, v); check("R1 device bucket not used by wb", v, 0);
    access(1, 0, 0, 0, 0, 4);
    check("R8 error sticky", int'(last_err), 1);
  endtask

  task automatic t_device();
    int v;
    access(1, 0, 0, 0, 1, 5);
    read(0, 0, exp_bucket(0, 1, 5), v); check("R2 device bucket", v, 1);
    read(0, 0, 2, v); check("R2 ctx bucket not used", v, 0);
  endtask

  task automatic t_both();
    int v;
    access(1, 1, 2, 0, 0, 4);
    read(0, 2, 1, v); check("R4 dual strobe hit", v, 1);
    read(1, 2, 1, v); check("R4 dual strobe miss", v, 1);
  endtask

  task automatic t_saturate();
    int v;
    for (int i = 0; i < 17; i++) access(1, 0, 1, 0, 0, 7);
    read(0, 1, 1, v); check("R5 saturated", v, int'(MAXV));
    read(1, 1, 1, v); check("R5 miss twin unchanged", v, 0);
  endtask

  task automatic t_limit();
    load_limit(3);
    access(0, 1, 0, 0, 0, 0); check("R6 stop after miss1", int'(last_stop), 0);
    access(1, 0, 0, 0, 0, 0); check("R6 hit no budget use", int'(last_stop), 0);
    access(0, 1, 0, 0, 0, 0); check("R6 stop after miss2", int'(last_stop), 0);
    access(0, 1, 0, 0, 0, 0); check("R6 stop after miss3", int'(last_stop), 1);
    @(negedge clk); check("R6 stop one cycle", int'(stop), 0);
    access(0, 1, 0, 0, 0, 0); check("R6 no second pulse", int'(last_stop), 0);
  endtask

  task automatic t_zero_limit();
    int seen = 0;
    load_limit(0);
    for (int i = 0; i < 4; i++) begin
      access(0, 1, 1, 0, 0, 1);
      if (last_stop) seen++;
    end
    check("R7 zero budget never stops", seen, 0);
  endtask

  task automatic t_clear();
    int v;
    load_limit(2);
    access(0, 1, 2, 0, 0, 2);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    check("R10 err cleared", int'(err), 0);
    read(0, 1, 1, v); check("R10 hit counter cleared", v, 0);
    read(1, 2, 2, v); check("R10 miss counter cleared", v, 0);
    access(0, 1, 2, 0, 0, 2); check("R10 budget kept across clear", int'(last_stop), 1);
  endtask

  task automatic t_read_timing();
    @(negedge clk); rd_en = 1; rd_miss = 1; rd_cmd = 2; rd_bkt = 2;
    check("R9 valid not early", int'(rd_valid), 0);
    @(negedge clk); rd_en = 0;
    check("R9 valid next cycle", int'(rd_valid), 1);
    check("R9 data next cycle", int'(rd_data), 1);
    @(negedge clk);
    check("R9 valid drops", int'(rd_valid), 0);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cpu_buckets();
    t_writeback();
    t_device();
    t_both();
    t_saturate();
    t_limit();
    t_zero_limit();
    t_clear();
    t_read_timing();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule